// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Phase Generator

The block is a chain of D flip-flops wired as a twisted ring. Every stage takes the value of the stage before it, and the first stage takes the inverse of the last. With `NUM_STAGES` stages the ring walks through `2*NUM_STAGES` distinct patterns. A decoder turns each pattern into its own phase line. Each phase line is a two-input AND of two adjacent stages, so a repeating set of non-overlapping timing strobes comes out with one gate per strobe.

A ring of this kind can power up in, or be pushed into, a pattern that is not on the main cycle. A plain ring would then circulate among such patterns forever. The block alters the input of one stage so that every unused pattern drains back into the main cycle, while the main cycle itself is unchanged.

- For rings of three to five stages, the third stage takes `B AND (A OR C)` instead of `B`.
- For longer rings, any pattern with more than one boundary between adjacent stages shifts in all zeros.

A synchronous seed port loads an arbitrary pattern. This lets a system start at any phase and lets the recovery path be exercised.

Top module: `twisted_ring_timer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the stage vector becomes all zeros. One cycle after that edge `phaseOut` equals 1 (only bit 0 high). Reset takes priority over seeding and advancing.
- R2: With `rst` and `seedLoad` low and `advEn` low, the stage vector and `phaseOut` keep their values across clock edges.
- R3: With `advEn` high and the ring on its main cycle, each edge moves the value of stage i-1 into stage i (bit 0 is the first stage) and loads bit 0 with the inverse of the top bit. For five stages, written first stage first, the order from reset is 00000, 10000, 11000, 11100, 11110, 11111, 01111, 00111, 00011, 00001.
- R4: On the main cycle the pattern repeats exactly every `2*NUM_STAGES` advancing edges.
- R5: In the k-th pattern of the main cycle (k counted from the all-zeros pattern, 0 to 2n-1), `phaseOut` equals `1 << k`: exactly one line is high. Line 0 is NOT(first) AND NOT(last). Line k for 1 ≤ k < n is stage k-1 AND NOT stage k. Line n is first AND last. Line n+j for j ≥ 1 is NOT stage j-1 AND stage j.
- R6: While `rst` is low, `seedLoad` high at an edge loads `seedValue` into the stage vector, whatever the level of `advEn`.
- R7: From any pattern that is not on the main cycle, with `advEn` held high, the ring reaches a main-cycle pattern within `3*NUM_STAGES` edges. From then on it follows R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset to the all-zeros pattern |
| advEn | input | 1 | Advance the ring by one step on this edge |
| seedLoad | input | 1 | Load `seedValue` into the stages on this edge |
| seedValue | input | NUM_STAGES | Pattern to load, bit 0 is the first stage |
| stageQ | output | NUM_STAGES | Current stage vector, bit 0 is the first stage |
| phaseOut | output | 2*NUM_STAGES | Decoded phase strobes, one per main-cycle pattern |

## Verification
The properties assume that `rst`, `seedLoad`, `advEn` and `seedValue` change only away from the rising edge. The recovery bound also assumes that nothing reseeds the ring or stalls it for good while it is off the main cycle, so the off-cycle counter restarts on every seed.

The stimulus drives every input on the falling edge. It lets the ring run freely after each seed. The only off-cycle patterns it creates come through the seed port, and it then holds `advEn` high until the ring is back on the main cycle.

// File: rtl/ring_timer_pkg.sv
package ring_timer_pkg;

  // Strobes from the control slice to the stage datapath, one per edge.
  typedef struct packed {
    logic clearAll;   // force every stage to zero
    logic loadSeed;   // take the external seed pattern
    logic shiftOn;    // advance the ring one step
  } ringStrobe_t;

endpackage

// File: rtl/ring_timer_ctrl.sv
module ring_timer_ctrl
  import ring_timer_pkg::*;
(
  input  logic        rst,
  input  logic        advEn,
  input  logic        seedLoad,
  output ringStrobe_t strobe
);

  // Fixed priority: reset, then seed, then advance; none of them means hold.
  always_comb begin
    strobe          = '0;
    strobe.clearAll = rst;
    strobe.loadSeed = !rst && seedLoad;
    strobe.shiftOn  = !rst && !seedLoad && advEn;
  end

endmodule

// File: rtl/ring_timer_stages.sv
module ring_timer_stages
  import ring_timer_pkg::*;
#(
  parameter int NUM_STAGES = 5
) (
  input  logic                  clk,
  input  ringStrobe_t           strobe,
  input  logic [NUM_STAGES-1:0] seedValue,
  output logic [NUM_STAGES-1:0] stageQ
);

  // Short rings are repaired by a single modified stage input; longer rings
  // contain stable off-cycle patterns that a local term cannot break.
  localparam bit USE_LOCAL_FIX = (NUM_STAGES <= 5);
  localparam int TALLY_W       = $clog2(NUM_STAGES) + 1;

  logic [NUM_STAGES-1:0] ringReg;
  logic [NUM_STAGES-1:0] shiftNext;

  if (USE_LOCAL_FIX) begin : g_local_fix
    // Third stage refuses to pass an isolated one (0,1,0 around it).
    assign shiftNext[0] = ~ringReg[NUM_STAGES-1];
    assign shiftNext[1] = ringReg[0];
    assign shiftNext[2] = ringReg[1] & (ringReg[0] | ringReg[2]);
    for (genvar i = 3; i < NUM_STAGES; i++) begin : g_tail
      assign shiftNext[i] = ringReg[i-1];
    end
  end else begin : g_global_fix
    logic [NUM_STAGES-1:0] plainNext;
    logic [TALLY_W-1:0]    edgeTally;

    assign plainNext = {ringReg[NUM_STAGES-2:0], ~ringReg[NUM_STAGES-1]};

    // Main-cycle patterns have at most one boundary between neighbours.
    always_comb begin
      edgeTally = '0;
      for (int i = 1; i < NUM_STAGES; i++) begin
        edgeTally = edgeTally + TALLY_W'(ringReg[i] ^ ringReg[i-1]);
      end
    end

    assign shiftNext = (edgeTally > TALLY_W'(1)) ? '0 : plainNext;
  end

  always_ff @(posedge clk) begin
    if (strobe.clearAll) begin
      ringReg <= '0;
    end else if (strobe.loadSeed) begin
      ringReg <= seedValue;
    end else if (strobe.shiftOn) begin
      ringReg <= shiftNext;
    end
  end

  assign stageQ = ringReg;

endmodule

// File: rtl/ring_timer_decode.sv
module ring_timer_decode #(
  parameter int NUM_STAGES = 5
) (
  input  logic [NUM_STAGES-1:0]   stageQ,
  output logic [2*NUM_STAGES-1:0] phaseOut
);

  localparam int PHASES = 2 * NUM_STAGES;

  // One two-input AND per phase, picking the single boundary of each pattern.
  for (genvar k = 0; k < PHASES; k++) begin : g_tap
    if (k == 0) begin : g_allZero
      assign phaseOut[k] = ~stageQ[0] & ~stageQ[NUM_STAGES-1];
    end else if (k < NUM_STAGES) begin : g_fillOnes
      assign phaseOut[k] = stageQ[k-1] & ~stageQ[k];
    end else if (k == NUM_STAGES) begin : g_allOne
      assign phaseOut[k] = stageQ[0] & stageQ[NUM_STAGES-1];
    end else begin : g_fillZeros
      assign phaseOut[k] = ~stageQ[k-NUM_STAGES-1] & stageQ[k-NUM_STAGES];
    end
  end

endmodule

// File: rtl/twisted_ring_timer.sv
module twisted_ring_timer
  import ring_timer_pkg::*;
#(
  parameter int NUM_STAGES = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    advEn,
  input  logic                    seedLoad,
  input  logic [NUM_STAGES-1:0]   seedValue,
  output logic [NUM_STAGES-1:0]   stageQ,
  output logic [2*NUM_STAGES-1:0] phaseOut
);

  ringStrobe_t strobe;

  ring_timer_ctrl u_ctrl (
    .rst      (rst),
    .advEn    (advEn),
    .seedLoad (seedLoad),
    .strobe   (strobe)
  );

  ring_timer_stages #(.NUM_STAGES(NUM_STAGES)) u_stages (
    .clk       (clk),
    .strobe    (strobe),
    .seedValue (seedValue),
    .stageQ    (stageQ)
  );

  ring_timer_decode #(.NUM_STAGES(NUM_STAGES)) u_decode (
    .stageQ   (stageQ),
    .phaseOut (phaseOut)
  );

endmodule

// File: rtl/ring_timer_chk.sv
module ring_timer_chk #(
  parameter int NUM_STAGES = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    advEn,
  input logic                    seedLoad,
  input logic [NUM_STAGES-1:0]   seedValue,
  input logic [NUM_STAGES-1:0]   stageQ,
  input logic [2*NUM_STAGES-1:0] phaseOut
);

  localparam int LIMIT = 3 * NUM_STAGES;
  localparam int RUN_W = $clog2(LIMIT + 2) + 1;

  logic             onCycle;
  logic [RUN_W-1:0] badRun;

  assign onCycle = ($countones(stageQ[NUM_STAGES-1:1] ^ stageQ[NUM_STAGES-2:0]) <= 1);

  // Edges spent advancing while off the main cycle since the last seed.
  always_ff @(posedge clk) begin
    if (rst || seedLoad || onCycle) begin
      badRun <= '0;
    end else if (advEn && badRun != RUN_W'(LIMIT + 1)) begin
      badRun <= badRun + RUN_W'(1);
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (stageQ == '0 && phaseOut == (2*NUM_STAGES)'(1)));

  // R2
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!seedLoad && !advEn) |=> ($stable(stageQ) && $stable(phaseOut)));

  // R3
  ring_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!seedLoad && advEn && onCycle) |=>
      (stageQ == {$past(stageQ[NUM_STAGES-2:0]), ~$past(stageQ[NUM_STAGES-1])}));

  // R5
  one_phase_chk: assert property (@(posedge clk) disable iff (rst)
    onCycle |-> $countones(phaseOut) == 1);

  // R6
  seed_take_chk: assert property (@(posedge clk) disable iff (rst)
    seedLoad |=> (stageQ == $past(seedValue)));

  // R7
  recover_bound_chk: assert property (@(posedge clk) disable iff (rst)
    badRun <= RUN_W'(LIMIT));

endmodule

bind twisted_ring_timer ring_timer_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .advEn     (advEn),
  .seedLoad  (seedLoad),
  .seedValue (seedValue),
  .stageQ    (stageQ),
  .phaseOut  (phaseOut)
);

// File: tb/tb_twisted_ring_timer.sv
module tb_twisted_ring_timer;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 5;
  localparam int P          = 2 * N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         advEn = 1'b0;
  logic         seedLoad = 1'b0;
  logic [N-1:0] seedValue = '0;
  logic [N-1:0] stageQ;
  logic [P-1:0] phaseOut;

  int checks = 0;
  int fails  = 0;

  // Scoreboard queues: one entry per rising edge driven.
  logic [N-1:0] expStateQ[$];
  logic [P-1:0] expPhaseQ[$];
  int           kindQ[$];     // 0 state+phase, 1 state only, 2 nothing
  string        tagQ[$];

  // Reference model of the ring.
  bit modelValid = 1'b1;
  int modelK     = 0;

  twisted_ring_timer #(.NUM_STAGES(N)) dut (
    .clk       (clk),
    .rst       (rst),
    .advEn     (advEn),
    .seedLoad  (seedLoad),
    .seedValue (seedValue),
    .stageQ    (stageQ),
    .phaseOut  (phaseOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Pattern number k of the main cycle, bit 0 is the first stage.
  function automatic logic [N-1:0] stateOf(int k);
    logic [N-1:0] s;
    for (int i = 0; i < N; i++) s[i] = (k <= N) ? (i < k) : (i >= k - N);
    return s;
  endfunction

  function automatic int indexOf(logic [N-1:0] v);
    for (int k = 0; k < P; k++) if (stateOf(k) == v) return k;
    return -1;
  endfunction

  function automatic logic [P-1:0] phaseOf(int k);
    logic [P-1:0] one = 1;
    return one << k;
  endfunction

  // Driver: set inputs on the falling edge and queue what the next edge yields.
  task automatic drive(bit r, bit s, logic [N-1:0] sv, bit e, string tag);
    int kind;
    @(negedge clk);
    rst = r; seedLoad = s; seedValue = sv; advEn = e;
    if (r) begin
      modelValid = 1'b1; modelK = 0;
    end else if (s) begin
      modelK = indexOf(sv);
      modelValid = (modelK >= 0);
      if (!modelValid) modelK = 0;
    end else if (e) begin
      if (modelValid) modelK = (modelK + 1) % P;
    end
    if (r || modelValid) kind = 0;
    else if (s) kind = 1;
    else kind = 2;
    expStateQ.push_back(modelValid ? stateOf(modelK) : sv);
    expPhaseQ.push_back(phaseOf(modelK));
    kindQ.push_back(kind);
    tagQ.push_back(tag);
  endtask

  // Monitor: compare after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (kindQ.size() > 0) begin
        automatic logic [N-1:0] es = expStateQ.pop_front();
        automatic logic [P-1:0] ep = expPhaseQ.pop_front();
        automatic int           kd = kindQ.pop_front();
        automatic string        tg = tagQ.pop_front();
        if (kd <= 1) begin
          checks++;
          if (stageQ !== es) begin
            fails++;
            $display("FAIL %s stageQ actual %b expected %b", tg, stageQ, es);
          end
        end
        if (kd == 0) begin
          checks++;
          if (phaseOut !== ep) begin
            fails++;
            $display("FAIL %s phaseOut actual %b expected %b", tg, phaseOut, ep);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    drive(1, 0, '0, 0, "R1");
    drive(1, 0, '0, 1, "R1");

    // R3 R4 R5: two full laps plus a little
    for (int i = 0; i < 2 * P + 3; i++) drive(0, 0, '0, 1, "R3_R4_R5");

    // R2: hold
    for (int i = 0; i < 3; i++) drive(0, 0, '0, 0, "R2");
    drive(0, 0, '0, 1, "R3");

    // R6: seed with advance off and on, then reset overriding a seed (R1)
    drive(0, 1, stateOf(7), 0, "R6");
    drive(0, 1, stateOf(2), 1, "R6");
    drive(0, 0, '0, 1, "R3");
    drive(1, 1, stateOf(4), 1, "R1");
    drive(0, 0, '0, 1, "R3");

    // R7: every off-cycle pattern drains back and then follows the cycle
    for (int v = 0; v < (1 << N); v++) begin
      if (indexOf(N'(v)) < 0) begin
        automatic int steps = 0;
        automatic int idx   = -1;
        drive(0, 1, N'(v), 0, "R6");
        while (idx < 0 && steps < 3 * N) begin
          drive(0, 0, '0, 1, "R7");
          @(posedge clk);
          #2;
          steps++;
          idx = indexOf(stageQ);
        end
        checks++;
        if (idx < 0) begin
          fails++;
          $display("FAIL R7 from %b actual off-cycle after %0d edges expected on-cycle within %0d",
                   N'(v), steps, 3 * N);
        end else begin
          modelValid = 1'b1;
          modelK = idx;
          for (int j = 0; j < 3; j++) drive(0, 0, '0, 1, "R7");
        end
      end
    end

    repeat (3) @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule